// File: doc/BRIEF.md
# Crosspoint Connection Select Decoder

This block drives the gate enables of a small bidirectional crosspoint. The crosspoint has two banks, A and B, and four shared output ports, SW0 to SW3. Each bank has a 2-bit select code that names the port it should reach, and an enable bit. The block turns these into eight registered, one-hot switch enables: four for bank A and four for bank B. Each analog channel is modelled as one enable bit.

The codes come from one of two sources, chosen by a static mode pin:
- **Mode 0:** dedicated control pins.
- **Mode 1:** fields of an 8-bit configuration word held elsewhere. The block only sees that word as an input.

The mode pin passes through a two-flop synchronizer before it steers the source multiplexer. When both banks request the same port, bank A keeps it and bank B is left unconnected.

Every output is a flop. A change of select therefore moves an enable cleanly from one port to another between clock edges, with no two-hot state. An asynchronous active-low reset opens every switch.

Top module: `xbar_sel_decoder`

## Requirements
- R1: An enabled bank asserts exactly one of its four enables, the one whose index equals its select code (code 00 gives SW0, 01 gives SW1, 10 gives SW2, 11 gives SW3; bit i of an enable vector is SWi).
- R2: A bank whose enable bit is 0 asserts none of its four enables.
- R3: If bank A is enabled and both select codes are equal, bank A connects as in R1 and all four bank B enables are 0. If bank A is disabled, bank B connects normally.
- R4: With the synchronized mode at 0, the source is the control pins:
  - bank A select is `pin_a_sel`, bank A enable is `pin_a_en`;
  - bank B select is `pin_b_sel`, bank B enable is `pin_b_en`;
  - `cfg_word` has no effect.
- R5: With the synchronized mode at 1, the source is `cfg_word`:
  - bit 7 is the B enable, bits 6:5 the B select;
  - bit 4 is the A enable, bits 3:2 the A select;
  - bits 1:0 and all control pins have no effect.
- R6: In mode 1 with `cfg_word` at 8'h00, all eight enables are 0.
- R7: Outputs are registered. Inputs present before a rising clock edge appear on the outputs just after that edge and hold until the next edge.
- R8: While `rst_n` is low, all eight enables are 0 immediately, without waiting for a clock edge.
- R9: A change of `mode_pin` takes effect on the outputs after the third rising edge that follows it. The first two edges still use the old source.
- R10: At every clock edge, each bank has at most one enable asserted, and no port index has both banks' enables asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pin | input | 1 | Source select: 0 = control pins, 1 = configuration word |
| pin_a_sel | input | 2 | Bank A select code, pin source |
| pin_a_en | input | 1 | Bank A enable, pin source |
| pin_b_sel | input | 2 | Bank B select code, pin source |
| pin_b_en | input | 1 | Bank B enable, pin source |
| cfg_word | input | 8 | Configuration word: [7] B enable, [6:5] B select, [4] A enable, [3:2] A select, [1:0] unused |
| sw_en_a | output | 4 | Bank A gate enables, bit i connects A to SWi |
| sw_en_b | output | 4 | Bank B gate enables, bit i connects B to SWi |

## Verification
Timing of results:
- A change on the select, enable or configuration inputs is due after the first rising edge that follows it.
- A change of the mode pin is due only after the third rising edge.
- Reset clears the outputs with no edge at all.

How the checks keep to that timing:
- The driver changes inputs on the falling edge and queues one expected pair of enable vectors per clock.
- The monitor compares each queued pair shortly after the next rising edge.
- Around a mode flip, the driver queues the old-source result for the first two cycles and the new-source result for the third.
- The reset check samples the outputs a fraction of a cycle after `rst_n` falls, before any edge.

// File: rtl/xbar_sel_decoder.sv
module xbar_sel_decoder #(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NOUT       = 1 << SEL_W,
  localparam int A_SEL_LO   = 2,
  localparam int A_EN_BIT   = A_SEL_LO + SEL_W,
  localparam int B_SEL_LO   = A_EN_BIT + 1,
  localparam int B_EN_BIT   = B_SEL_LO + SEL_W,
  localparam int CFG_W      = B_EN_BIT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_pin,
  input  logic [SEL_W-1:0] pin_a_sel,
  input  logic             pin_a_en,
  input  logic [SEL_W-1:0] pin_b_sel,
  input  logic             pin_b_en,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [NOUT-1:0]  sw_en_a,
  output logic [NOUT-1:0]  sw_en_b
);

  logic [SYNC_STAGES-1:0] mode_sync;
  logic                   mode_s;
  logic [SEL_W-1:0]       a_sel, b_sel;
  logic                   a_en, b_en, clash;
  logic [NOUT-1:0]        a_hot, b_hot;
  logic                   unused_cfg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_sync <= '0;
    else        mode_sync <= {mode_sync[SYNC_STAGES-2:0], mode_pin};

  assign mode_s = mode_sync[SYNC_STAGES-1];

  assign a_sel = mode_s ? cfg_word[A_SEL_LO +: SEL_W] : pin_a_sel;
  assign a_en  = mode_s ? cfg_word[A_EN_BIT]          : pin_a_en;
  assign b_sel = mode_s ? cfg_word[B_SEL_LO +: SEL_W] : pin_b_sel;
  assign b_en  = mode_s ? cfg_word[B_EN_BIT]          : pin_b_en;

  assign unused_cfg = ^cfg_word[A_SEL_LO-1:0];

  assign clash = a_en && (a_sel == b_sel);
  assign a_hot = a_en ? ({{(NOUT-1){1'b0}}, 1'b1} << a_sel) : '0;
  assign b_hot = (b_en && !clash) ? ({{(NOUT-1){1'b0}}, 1'b1} << b_sel) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sw_en_a <= '0;
      sw_en_b <= '0;
    end else begin
      sw_en_a <= a_hot;
      sw_en_b <= b_hot;
    end

endmodule

// File: rtl/xbar_sel_decoder_chk.sv
module xbar_sel_decoder_chk #(
  parameter int SEL_W = 2,
  localparam int NOUT = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_s,
  input logic [SEL_W-1:0] pin_a_sel,
  input logic             pin_a_en,
  input logic [SEL_W-1:0] pin_b_sel,
  input logic             pin_b_en,
  input logic [7:0]       cfg_word,
  input logic [NOUT-1:0]  sw_en_a,
  input logic [NOUT-1:0]  sw_en_b
);

  // R10
  a_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_en_a));
  // R10
  b_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_en_b));
  // R10
  no_share_chk: assert property (@(posedge clk) disable iff (!rst_n) (sw_en_a & sw_en_b) == '0);
  // R8
  rst_clear_chk: assert property (@(posedge clk) !rst_n |-> (sw_en_a == '0 && sw_en_b == '0));
  // R2
  a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !pin_a_en) |=> sw_en_a == '0);
  // R1
  a_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && pin_a_en && pin_a_sel == 2'd3) |=> sw_en_a[3]);
  // R3
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && pin_a_en && pin_a_sel == pin_b_sel) |=> sw_en_b == '0);
  // R6
  cfg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && cfg_word[7:2] == 6'd0) |=> (sw_en_a == '0 && sw_en_b == '0));

endmodule

bind xbar_sel_decoder xbar_sel_decoder_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_s(mode_s),
  .pin_a_sel(pin_a_sel), .pin_a_en(pin_a_en),
  .pin_b_sel(pin_b_sel), .pin_b_en(pin_b_en),
  .cfg_word(cfg_word), .sw_en_a(sw_en_a), .sw_en_b(sw_en_b)
);

// File: tb/xbar_sel_decoder_bench.sv
`timescale 1ns/1ps
module xbar_sel_decoder_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_pin = 0;
  logic [1:0] pin_a_sel = 0, pin_b_sel = 0;
  logic       pin_a_en = 0, pin_b_en = 0;
  logic [7:0] cfg_word = 0;
  logic [3:0] sw_en_a, sw_en_b;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  xbar_sel_decoder u_xbar_sel_decoder (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
    .pin_a_sel(pin_a_sel), .pin_a_en(pin_a_en),
    .pin_b_sel(pin_b_sel), .pin_b_en(pin_b_en),
    .cfg_word(cfg_word), .sw_en_a(sw_en_a), .sw_en_b(sw_en_b));

  function automatic logic [7:0] model(logic ae, logic [1:0] as, logic be, logic [1:0] bs);
    logic [3:0] ea, eb;
    ea = ae ? (4'b0001 << as) : 4'b0000;
    eb = (be && !(ae && as == bs)) ? (4'b0001 << bs) : 4'b0000;
    return {ea, eb};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got a=%b b=%b, expected a=%b b=%b", tag, act[7:4], act[3:0], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic drive(logic [1:0] as, logic ae, logic [1:0] bs, logic be,
                       logic [7:0] cfg, logic [7:0] exp, string tag);
    @(negedge clk);
    pin_a_sel = as; pin_a_en = ae; pin_b_sel = bs; pin_b_en = be; cfg_word = cfg;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {sw_en_a, sw_en_b}, e);
        check({t, " R10"}, {7'd0, ($onehot0(sw_en_a) && $onehot0(sw_en_b) && (sw_en_a & sw_en_b) == 0)}, 8'd1);
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #12;
    check("R8 reset idle", {sw_en_a, sw_en_b}, 8'h00);
    @(negedge clk); rst_n = 1;

    // R4 R1 R2 R3: mode 0, every pin pattern, cfg holds opposing garbage
    for (int i = 0; i < 64; i++) begin
      logic [5:0] v;
      v = i[5:0];
      drive(v[1:0], v[2], v[4:3], v[5], {~v, 2'b11},
            model(v[2], v[1:0], v[5], v[4:3]), "R4/R1/R2/R3 pins");
    end
    drain();

    // R7: output holds between edges, changes right after the edge
    drive(2'd2, 1, 2'd0, 1, 8'h00, 8'h41, "R7 step");
    drain();
    #3 check("R7 hold mid-cycle", {sw_en_a, sw_en_b}, 8'h41);

    // R8: asynchronous clear without an edge
    @(negedge clk); #1 rst_n = 0;
    #1 check("R8 async clear", {sw_en_a, sw_en_b}, 8'h00);
    @(negedge clk); rst_n = 1;

    // R9: pins say A->SW1, cfg says A->SW3; flip mode
    drive(2'd1, 1, 2'd0, 0, 8'h1C, 8'h20, "R9 pre");
    drain();
    @(negedge clk); mode_pin = 1;
    exp_q.push_back(8'h20); tag_q.push_back("R9 edge1 old");
    @(negedge clk);
    exp_q.push_back(8'h20); tag_q.push_back("R9 edge2 old");
    @(negedge clk);
    exp_q.push_back(8'h80); tag_q.push_back("R9 edge3 new");
    drain();

    // R6
    drive(2'd1, 1, 2'd2, 1, 8'h00, 8'h00, "R6 cfg zero");
    drive(2'd3, 1, 2'd0, 1, 8'h03, 8'h00, "R6 cfg zero with low bits");

    // R5 R1 R2 R3: mode 1, every field pattern; pins and low bits vary
    for (int i = 0; i < 64; i++) begin
      logic [5:0] v;
      v = i[5:0];
      drive(~v[1:0], ~v[2], ~v[4:3], ~v[5], {v[5], v[4:3], v[2], v[1:0], i[1:0]},
            model(v[2], v[1:0], v[5], v[4:3]), "R5/R1/R2/R3 cfg");
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule